// File: doc/BRIEF.md
# Streaming Reed-Solomon Syndrome Generator over GF(4096)

This block computes the eight syndromes of a Reed-Solomon codeword while the bytes of a flash page stream past it. It packs the bytes into 12-bit symbols. Every symbol updates eight accumulators in Horner form: each accumulator multiplies its value by its own root and then XORs in the symbol. After the last byte, any partial symbol is filled with zeros and folded in. The syndromes then appear packed two per 32-bit word, together with a result word whose error flag reports whether any syndrome is nonzero. Error location and correction belong to a later stage.

The field GF(4096) is built as a quadratic extension of GF(64), which uses x^6 + x + 1 as its reduction polynomial. Each root is a power of a fixed generator. The power is computed at elaboration time, so each accumulator holds a constant multiplier made of XOR gates.

Top module: `rs_syndrome_unit`

## Requirements
- R1: Field products use the tower form. For 12-bit a and b, split into 6-bit halves h and l, the product's upper half is (ah^al)*(bh^bl) ^ al*bl and its lower half is (ah*bh)*0x21 ^ al*bl. Here * is GF(64) multiplication modulo x^6 + x + 1, and the 12-bit result is {upper, lower}.
- R2: Syndrome k (k = 0..7) uses root r_k = G^(k+1) with G = 0xE01. Each accepted symbol c updates S_k to S_k*r_k ^ c. A cycle with no symbol leaves every S_k unchanged.
- R3: Symbols are formed from a bit string made of four zero bits followed by the bytes, each byte MSB first, cut into 12-bit pieces MSB first. So symbol 0 is {0000, b0}, symbol 1 is {b1, b2[7:4]}, symbol 2 is {b2[3:0], b3}, and the pattern repeats every three bytes.
- R4: When the final byte (in_last high) leaves a partial symbol, that symbol is padded with zero bits on the right and folded in one cycle after the final byte. When the final byte completes a symbol, no extra symbol follows.
- R5: A start pulse clears all syndromes, the packing state and res_valid by the next cycle. Bytes presented in the start cycle are not taken.
- R6: done is high for exactly one cycle, the first cycle in which the final syndromes are visible. That is one cycle after the final byte when no padding is needed and two cycles after it otherwise. res_valid rises with done and stays high, with the syndromes held, until the next start.
- R7: Output word w carries S_(2w) in bits 11:0 and S_(2w+1) in bits 27:16. All other bits are zero.
- R8: result_word bit 18 is 1 exactly when any syndrome is nonzero. All other bits of result_word are zero.
- R9: Idle cycles (in_valid low) between bytes do not change the result.
- R10: After reset, done and res_valid are low and every syndrome word and result_word read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new codeword; clears all accumulators |
| in_valid | input | 1 | in_byte carries a page byte this cycle |
| in_byte | input | 8 | Page byte |
| in_last | input | 1 | Marks the final byte of the codeword (qualified by in_valid) |
| done | output | 1 | One-cycle pulse when the final syndromes appear |
| res_valid | output | 1 | Syndromes are complete and held |
| syn_words | output | 128 | Four words of two syndromes each, word w at bits 32w+31:32w |
| result_word | output | 32 | Error flag at bit 18, other bits zero |

## Verification
The assertions assume a clean codeword framing. start is never raised together with in_valid. No byte arrives in the cycle right after a final byte. A second final byte never follows without a start in between. The done-pulse and padding properties depend on that framing. The bench issues a start before every stream and leaves at least one idle cycle after each final byte. It also covers a start issued mid-stream and idle gaps between bytes. Expected syndromes come from a direct power-sum evaluation of a bit-string model of the packing, not from a Horner loop.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;

  localparam int HALF_W = 6;
  localparam int SYM_W  = 2 * HALF_W;

  typedef logic [HALF_W-1:0] gf_half_t;
  typedef logic [SYM_W-1:0]  gf_sym_t;

  // constant of the quadratic extension (X^2 + X + A^-1 term)
  localparam gf_half_t TOWER_K = 6'h21;
  // reduction of x^6 in GF(64): x^6 = x + 1
  localparam gf_half_t RED64   = 6'h03;

  typedef enum logic [1:0] {
    PH_NIB  = 2'd0,   // a 4-bit head is pending, next byte completes a symbol
    PH_HEAD = 2'd1,   // nothing pending, next byte is the top of a symbol
    PH_TAIL = 2'd2    // top byte held, next byte's high nibble completes it
  } pk_phase_e;

  function automatic gf_half_t gf64_mul(gf_half_t a, gf_half_t b);
    gf_half_t acc;
    gf_half_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < HALF_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[HALF_W-2:0], 1'b0} ^ (sh[HALF_W-1] ? RED64 : '0);
    end
    return acc;
  endfunction

  function automatic gf_sym_t gf4096_mul(gf_sym_t a, gf_sym_t b);
    gf_half_t ah, al, bh, bl, lo_prod, hi, lo;
    ah = a[SYM_W-1:HALF_W];
    al = a[HALF_W-1:0];
    bh = b[SYM_W-1:HALF_W];
    bl = b[HALF_W-1:0];
    lo_prod = gf64_mul(al, bl);
    hi = gf64_mul(ah ^ al, bh ^ bl) ^ lo_prod;
    lo = gf64_mul(gf64_mul(ah, bh), TOWER_K) ^ lo_prod;
    return {hi, lo};
  endfunction

  function automatic gf_sym_t gf4096_pow(gf_sym_t base, int unsigned e);
    gf_sym_t acc;
    acc = gf_sym_t'(1);
    for (int unsigned i = 0; i < e; i++) acc = gf4096_mul(acc, base);
    return acc;
  endfunction

endpackage

// File: rtl/rs_sym_packer.sv
module rs_sym_packer
  import rs_syn_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    in_valid,
  input  logic [7:0] in_byte,
  input  logic    in_last,
  output logic    sym_valid,
  output gf_sym_t sym_data,
  output logic    sym_final
);

  pk_phase_e phase;
  logic [3:0] nib;
  logic [7:0] hold;
  logic       flush_q;
  gf_sym_t    flush_sym;

  logic    byte_ok;
  logic    main_fire;
  gf_sym_t main_sym;

  always_comb begin
    byte_ok   = in_valid && !start;
    main_fire = byte_ok && (phase != PH_HEAD);
    main_sym  = (phase == PH_NIB) ? {nib, in_byte} : {hold, in_byte[7:4]};
    sym_valid = main_fire || flush_q;
    sym_data  = flush_q ? flush_sym : main_sym;
    sym_final = flush_q || (main_fire && in_last && (phase == PH_NIB));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_NIB;
      nib       <= '0;
      hold      <= '0;
      flush_q   <= 1'b0;
      flush_sym <= '0;
    end else if (start) begin
      phase   <= PH_NIB;
      nib     <= '0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= 1'b0;
      if (byte_ok) begin
        if (in_last) begin
          phase     <= PH_NIB;
          nib       <= '0;
          flush_q   <= (phase != PH_NIB);
          flush_sym <= (phase == PH_HEAD) ? {in_byte, 4'h0} : {in_byte[3:0], 8'h00};
        end else begin
          case (phase)
            PH_NIB:  phase <= PH_HEAD;
            PH_HEAD: begin
              hold  <= in_byte;
              phase <= PH_TAIL;
            end
            default: begin
              nib   <= in_byte[3:0];
              phase <= PH_NIB;
            end
          endcase
        end
      end
    end
  end

  // a padded symbol only ever follows a final byte
  assert_flush_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> $past(in_valid && in_last && !start));

  // phase stays within the three legal packing states
  assert_phase_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase != pk_phase_e'(2'd3));

endmodule

// File: rtl/rs_syn_acc.sv
module rs_syn_acc
  import rs_syn_pkg::*;
#(
  parameter gf_sym_t ROOT = 12'hE01
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr,
  input  logic    en,
  input  gf_sym_t sym,
  output gf_sym_t syn
);

  gf_sym_t next_syn;

  always_comb next_syn = gf4096_mul(syn, ROOT) ^ sym;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   syn <= '0;
    else if (clr) syn <= '0;
    else if (en)  syn <= next_syn;
  end

  // accumulator holds when no symbol is offered
  assert_acc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(syn));

endmodule

// File: rtl/rs_syn_out.sv
module rs_syn_out
  import rs_syn_pkg::*;
#(
  parameter int NUM_SYN = 8,
  parameter int WORD_W  = 32,
  parameter int ODD_LSB = 16,
  parameter int ERR_BIT = 18,
  localparam int NUM_WORDS = NUM_SYN / 2
) (
  input  gf_sym_t [NUM_SYN-1:0] syn,
  output logic [NUM_WORDS*WORD_W-1:0] words,
  output logic [WORD_W-1:0]     result_word
);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_comb begin
      words[w*WORD_W +: WORD_W] = '0;
      words[w*WORD_W +: SYM_W]  = syn[2*w];
      words[w*WORD_W + ODD_LSB +: SYM_W] = syn[2*w+1];
    end
  end

  always_comb begin
    result_word = '0;
    result_word[ERR_BIT] = |syn;
  end

endmodule

// File: rtl/rs_syndrome_unit.sv
module rs_syndrome_unit
  import rs_syn_pkg::*;
#(
  parameter int      NUM_SYN = 8,
  parameter gf_sym_t GEN     = 12'hE01,
  parameter int      WORD_W  = 32,
  parameter int      ERR_BIT = 18,
  localparam int     NUM_WORDS = NUM_SYN / 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        in_valid,
  input  logic [7:0]                  in_byte,
  input  logic                        in_last,
  output logic                        done,
  output logic                        res_valid,
  output logic [NUM_WORDS*WORD_W-1:0] syn_words,
  output logic [WORD_W-1:0]           result_word
);

  logic    sym_valid;
  gf_sym_t sym_data;
  logic    sym_final;
  logic    final_upd;
  gf_sym_t [NUM_SYN-1:0] syn_all;

  rs_sym_packer u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .in_last   (in_last),
    .sym_valid (sym_valid),
    .sym_data  (sym_data),
    .sym_final (sym_final)
  );

  for (genvar k = 0; k < NUM_SYN; k++) begin : g_acc
    localparam gf_sym_t ROOT_K = gf4096_pow(GEN, k + 1);
    rs_syn_acc #(.ROOT(ROOT_K)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start),
      .en    (sym_valid),
      .sym   (sym_data),
      .syn   (syn_all[k])
    );
  end

  assign final_upd = sym_valid && sym_final && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      res_valid <= 1'b0;
    end else if (start) begin
      done      <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      done <= final_upd;
      if (final_upd) res_valid <= 1'b1;
    end
  end

  rs_syn_out #(
    .NUM_SYN (NUM_SYN),
    .WORD_W  (WORD_W),
    .ODD_LSB (16),
    .ERR_BIT (ERR_BIT)
  ) u_out (
    .syn         (syn_all),
    .words       (syn_words),
    .result_word (result_word)
  );

  // start wipes every accumulator and the completion state
  assert_start_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ((syn_all == '0) && !res_valid && !done));

  // completion is a single-cycle pulse
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // a completion always comes with a valid result
  assert_done_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_valid);

  // result and syndromes are held until the next start
  assert_valid_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !start && !in_valid) |=> (res_valid && $stable(syn_all)));

endmodule

// File: tb/rs_syndrome_unit_test.sv
`timescale 1ns/1ps
module rs_syndrome_unit_test;

  localparam int NSYN   = 8;
  localparam int MAXB   = 2100;
  localparam int MAXS   = 1500;
  localparam logic [11:0] GENV = 12'hE01;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic in_last = 1'b0;
  logic done;
  logic res_valid;
  logic [127:0] syn_words;
  logic [31:0] result_word;

  int n_total = 0;
  int n_fail  = 0;

  logic [7:0]  bytes_q [MAXB];
  logic [11:0] syms_q  [MAXS];
  logic [11:0] exp_syn [NSYN];

  always #2 clk = ~clk;

  rs_syndrome_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_byte(in_byte), .in_last(in_last), .done(done), .res_valid(res_valid),
    .syn_words(syn_words), .result_word(result_word)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // GF(64): full polynomial product, then fold x^i into x^(i-6)+x^(i-5)
  function automatic logic [5:0] m64(logic [5:0] a, logic [5:0] b);
    logic [10:0] p = '0;
    for (int i = 0; i < 6; i++) if (b[i]) p = p ^ (11'(a) << i);
    for (int i = 10; i >= 6; i--) if (p[i]) begin
      p[i] = 1'b0;
      p[i-6] = ~p[i-6];
      p[i-5] = ~p[i-5];
    end
    return p[5:0];
  endfunction

  function automatic logic [11:0] m4096(logic [11:0] a, logic [11:0] b);
    logic [5:0] u, l;
    u = m64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ m64(a[5:0], b[5:0]);
    l = m64(m64(a[11:6], b[11:6]), 6'h21) ^ m64(a[5:0], b[5:0]);
    return {u, l};
  endfunction

  // bit-string model of the packing: 4 zero bits, then bytes MSB first
  function automatic int build_syms(int n);
    int total_bits = 4 + 8 * n;
    int ns = (total_bits + 11) / 12;
    for (int s = 0; s < ns; s++) begin
      logic [11:0] v = '0;
      for (int t = 0; t < 12; t++) begin
        int pos = 12 * s + t;
        logic bitv = 1'b0;
        if (pos >= 4 && pos < total_bits)
          bitv = bytes_q[(pos - 4) / 8][7 - ((pos - 4) % 8)];
        v[11 - t] = bitv;
      end
      syms_q[s] = v;
    end
    return ns;
  endfunction

  // direct power-sum evaluation: S = sum c_j * r^(ns-1-j)
  task automatic compute_expected(int n);
    int ns = build_syms(n);
    for (int k = 0; k < NSYN; k++) begin
      logic [11:0] r = 12'h001;
      logic [11:0] pw = 12'h001;
      logic [11:0] acc = '0;
      for (int e = 0; e <= k; e++) r = m4096(r, GENV);
      for (int j = ns - 1; j >= 0; j--) begin
        acc = acc ^ m4096(syms_q[j], pw);
        pw = m4096(pw, r);
      end
      exp_syn[k] = acc;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    in_valid = 1'b0;
    in_last = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic fill_bytes(int n, int seed);
    for (int i = 0; i < n; i++)
      bytes_q[i] = 8'((i * 37) + (seed * 11) + (i >> 3) + (i * i * 5));
  endtask

  // drive n bytes (last marked), check done timing and hold
  task automatic feed(int n, int gap, string tag);
    int flush_exp = ((n % 3) != 1) ? 1 : 0;
    int done_cnt = 0;
    int done_at = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gap != 0 && (i % 2) == 1) begin
        in_valid = 1'b0;
        in_last  = 1'b0;
        for (int g = 0; g < gap; g++) @(negedge clk);
      end
      in_valid = 1'b1;
      in_byte  = bytes_q[i];
      in_last  = (i == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    for (int p = 0; p < 4; p++) begin
      if (done) begin
        done_cnt++;
        if (done_at < 0) done_at = p;
      end
      if (p < 3) @(negedge clk);
    end
    check({"R6 done pulse count ", tag}, 32'(done_cnt), 32'd1);
    check({"R6 done timing ", tag}, 32'(done_at), 32'(flush_exp));
    check({"R6 result held valid ", tag}, {31'd0, res_valid}, 32'd1);
  endtask

  task automatic compare_out(string tag);
    logic any_nz = 1'b0;
    for (int w = 0; w < NSYN / 2; w++) begin
      check({"R2 R3 even syndrome ", tag}, {20'd0, syn_words[32*w +: 12]}, {20'd0, exp_syn[2*w]});
      check({"R2 R3 odd syndrome ", tag}, {20'd0, syn_words[32*w+16 +: 12]}, {20'd0, exp_syn[2*w+1]});
      check({"R7 pad bits zero ", tag},
            {24'd0, syn_words[32*w+12 +: 4], syn_words[32*w+28 +: 4]}, 32'd0);
    end
    for (int k = 0; k < NSYN; k++) if (exp_syn[k] != 0) any_nz = 1'b1;
    check({"R8 error flag word ", tag}, result_word, any_nz ? 32'h0004_0000 : 32'h0);
  endtask

  task automatic t_reset();
    check("R10 done after reset", {31'd0, done}, 32'd0);
    check("R10 valid after reset", {31'd0, res_valid}, 32'd0);
    check("R10 syndromes after reset", (|syn_words) ? 32'd1 : 32'd0, 32'd0);
    check("R10 result word after reset", result_word, 32'd0);
  endtask

  task automatic t_single_one();
    pulse_start();
    bytes_q[0] = 8'h01;
    feed(1, 0, "single byte");
    // symbol {0000,0x01} = 1 gives S_k = 1 for every root
    for (int k = 0; k < NSYN; k++) exp_syn[k] = 12'h001;
    compare_out("R1 single symbol one");
  endtask

  task automatic t_zero();
    pulse_start();
    for (int i = 0; i < 6; i++) bytes_q[i] = 8'h00;
    feed(6, 0, "zero bytes");
    for (int k = 0; k < NSYN; k++) exp_syn[k] = 12'h000;
    compare_out("R8 zero stream");
  endtask

  task automatic t_lengths();
    for (int n = 1; n <= 7; n++) begin
      pulse_start();
      fill_bytes(n, n + 3);
      compute_expected(n);
      feed(n, 0, $sformatf("R4 len %0d", n));
      compare_out($sformatf("R4 len %0d", n));
    end
  endtask

  task automatic t_gaps();
    pulse_start();
    fill_bytes(9, 21);
    compute_expected(9);
    feed(9, 2, "R9 gaps");
    compare_out("R9 gaps");
  endtask

  task automatic t_restart();
    pulse_start();
    fill_bytes(5, 40);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = bytes_q[i];
      in_last  = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R5 syndromes cleared by start", (|syn_words) ? 32'd1 : 32'd0, 32'd0);
    check("R5 valid cleared by start", {31'd0, res_valid}, 32'd0);
    fill_bytes(4, 55);
    compute_expected(4);
    feed(4, 0, "R5 restart");
    compare_out("R5 restart");
  endtask

  task automatic t_page();
    pulse_start();
    fill_bytes(2062, 7);
    compute_expected(2062);
    feed(2062, 0, "R1 full page");
    compare_out("R1 R2 full page");
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_total, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_one();
    t_zero();
    t_lengths();
    t_gaps();
    t_restart();
    t_page();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_total, n_fail);
    $finish;
  end

endmodule